// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that lets an external bus controller read and write a small bank of byte registers held in the surrounding host logic. It samples SCL and SDA with the system clock through synchronisers, recognises START, repeated START and STOP, and compares the address byte with a 7-bit device address set by parameter. After a write-direction address, the first data byte loads an 8-bit register pointer. Later bytes of the same transfer are page writes at the pointer. A read-direction address starts sequential reads from the pointer. The pointer steps by one after every data byte and wraps from 0xFF to 0x00.

Only the addresses listed in a parameter are mapped. A pointer byte or write byte that lands on an unmapped address is refused with NACK, but the transfer goes on and the pointer still moves. Unmapped addresses read back as 0x00. The block never drives SCL and never holds it low. On SDA it can only pull low or let go, through an output-enable pin.

The host side is a write stream plus a read lookup. `wr_valid` is a one-cycle beat carrying `wr_addr`/`wr_data`. It has no ready signal, because the bus cannot be stretched: the host must take every beat in the cycle it is offered. For reads, the host must present `rd_data` combinationally for whatever `rd_addr` shows. The block captures it in the cycle it starts shifting out a byte.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `wr_valid` is 0 and `rd_addr` is 0x00.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` is acknowledged, and its bit 0 selects the direction (1 = read). When the address does not match, the block sends no ACK and never pulls SDA. It also makes no write and leaves the pointer unchanged until the next START or STOP.
- R3: In a write-direction transfer, the first data byte loads the pointer. It is ACKed when its value is a mapped address and NACKed otherwise. The pointer is loaded in both cases.
- R4: A later write byte whose pointer is mapped is ACKed and produces exactly one `wr_valid` cycle, with `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R5: A write byte whose pointer is unmapped is NACKed and produces no `wr_valid`.
- R6: A read byte is sent MSB first. It equals `rd_data` at the pointer when the pointer is mapped, and 0x00 when it is not.
- R7: The pointer, visible on `rd_addr`, increments by one after every data byte read or written, whether mapped or not. It wraps from 0xFF to 0x00.
- R8: When the controller NACKs a read byte, SDA is released and stays released until a START or STOP. A repeated START keeps the pointer.
- R9: `sda_oe` changes only in the cycle after the synchronised SCL showed a falling edge, a START or a STOP. It therefore never changes while SCL is high.
- R10: A START or STOP releases SDA in the following cycle and restarts byte reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_valid | output | 1 | One-cycle write beat, no back-pressure |
| wr_addr | output | 8 | Register address of the write beat |
| wr_data | output | 8 | Data of the write beat |
| rd_addr | output | 8 | Current register pointer, used by the host for read lookup |
| rd_data | input | 8 | Host register value at `rd_addr`, combinational |

## Verification
The bench builds the block with device address 0x3A, two synchroniser stages, and a four-entry map of 0x00, 0x01, 0x10 and 0xFF. With both ends of the address space mapped, a page write or sequential read across the 0xFF-to-0x00 wrap crosses mapped-to-mapped. The gaps at 0x02 and 0x0F give unmapped neighbours on both sides of a mapped address, so ACK/NACK changes in the middle of a transfer and zero reads can be seen. A behavioural model with its own register image and pointer predicts every ACK bit, read byte and write beat. It checks the write port and the timing of SDA changes on every clock.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_PTR,
    ST_WR,
    ST_RD,
    ST_SKIP
  } tgt_state_e;

  // Events decoded from the synchronised bus lines, valid for one clock.
  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
    logic sda;
  } bus_evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);
  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic scl_q, sda_q;
  logic scl_now, sda_now;

  // Chain of flops per line; idle bus level is high.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh[0] <= 1'b1;
          sda_sh[0] <= 1'b1;
        end else begin
          scl_sh[0] <= scl_i;
          sda_sh[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh[s] <= 1'b1;
          sda_sh[s] <= 1'b1;
        end else begin
          scl_sh[s] <= scl_sh[s-1];
          sda_sh[s] <= sda_sh[s-1];
        end
      end
    end
  end

  assign scl_now = scl_sh[SYNC_STAGES-1];
  assign sda_now = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_now;
      sda_q <= sda_now;
    end
  end

  always_comb begin
    evt.rise  = scl_now & ~scl_q;
    evt.fall  = ~scl_now & scl_q;
    evt.start = scl_now & scl_q & sda_q & ~sda_now;
    evt.stop  = scl_now & scl_q & ~sda_q & sda_now;
    evt.sda   = sda_now;
  end
endmodule

// File: rtl/i2c_map_decode.sv
module i2c_map_decode #(
  parameter int                    NUM_REGS = 4,
  parameter int                    ADDR_W   = 8,
  parameter logic [NUM_REGS*ADDR_W-1:0] REG_MAP = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [NUM_REGS-1:0] match;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
    assign match[g] = (addr == REG_MAP[g*ADDR_W +: ADDR_W]);
  end

  assign hit = |match;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic              rx_hit,
  input  logic              ptr_hit,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] ptr,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  tgt_state_e        state;
  logic [CNT_W-1:0]  bitcnt;
  logic              in_ack;
  logic              rnw;
  logic              mnack;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] load;

  assign load = ptr_hit ? rd_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      rnw      <= 1'b0;
      mnack    <= 1'b0;
      tx       <= '0;
      rx_byte  <= '0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (evt.start) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (evt.stop) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_PTR, ST_WR: begin
            if (evt.rise && !in_ack && bitcnt != CNT_FULL) begin
              rx_byte <= {rx_byte[BYTE_W-2:0], evt.sda};
              bitcnt  <= bitcnt + 1'b1;
            end else if (evt.fall && in_ack) begin
              // End of the acknowledge slot.
              in_ack <= 1'b0;
              bitcnt <= '0;
              sda_oe <= 1'b0;
              if (state == ST_DEV) begin
                if (rnw) begin
                  state  <= ST_RD;
                  tx     <= load;
                  sda_oe <= ~load[BYTE_W-1];
                end else begin
                  state <= ST_PTR;
                end
              end else if (state == ST_PTR) begin
                state <= ST_WR;
              end
            end else if (evt.fall && bitcnt == CNT_FULL) begin
              // Byte complete: decide the acknowledge.
              if (state == ST_DEV) begin
                if (rx_byte[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rnw    <= rx_byte[0];
                  in_ack <= 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_PTR) begin
                ptr    <= rx_byte;
                sda_oe <= rx_hit;
                in_ack <= 1'b1;
              end else begin
                sda_oe <= ptr_hit;
                in_ack <= 1'b1;
                ptr    <= ptr + 1'b1;
                if (ptr_hit) begin
                  wr_valid <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= rx_byte;
                end
              end
            end
          end
          ST_RD: begin
            if (evt.rise) begin
              if (in_ack) begin
                mnack <= evt.sda;
              end else if (bitcnt != CNT_FULL) begin
                bitcnt <= bitcnt + 1'b1;
              end
            end else if (evt.fall) begin
              if (in_ack) begin
                in_ack <= 1'b0;
                bitcnt <= '0;
                if (mnack) begin
                  state  <= ST_SKIP;
                  sda_oe <= 1'b0;
                end else begin
                  tx     <= load;
                  sda_oe <= ~load[BYTE_W-1];
                end
              end else if (bitcnt == CNT_FULL) begin
                sda_oe <= 1'b0;
                in_ack <= 1'b1;
                ptr    <= ptr + 1'b1;
              end else if (bitcnt != '0) begin
                sda_oe <= ~tx[BYTE_W-2];
                tx     <= {tx[BYTE_W-2:0], 1'b0};
              end
            end
          end
          default: begin
            // Idle or ignoring the bus until the next START or STOP.
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]            DEV_ADDR    = 7'h3A,
  parameter int                    NUM_REGS    = 4,
  parameter logic [NUM_REGS*8-1:0] REG_MAP     = {8'hFF, 8'h10, 8'h01, 8'h00},
  parameter int                    SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       wr_valid,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);
  bus_evt_t          evt;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] ptr;
  logic              rx_hit, ptr_hit;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt   (evt)
  );

  i2c_map_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(BYTE_W), .REG_MAP(REG_MAP)) u_rx_dec (
    .addr (rx_byte),
    .hit  (rx_hit)
  );

  i2c_map_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(BYTE_W), .REG_MAP(REG_MAP)) u_ptr_dec (
    .addr (ptr),
    .hit  (ptr_hit)
  );

  i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .rx_hit   (rx_hit),
    .ptr_hit  (ptr_hit),
    .rd_data  (rd_data),
    .rx_byte  (rx_byte),
    .ptr      (ptr),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  assign rd_addr = ptr;
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
#(
  parameter int                    NUM_REGS = 4,
  parameter logic [NUM_REGS*8-1:0] REG_MAP  = '0
) (
  input logic       clk,
  input logic       rst_n,
  input bus_evt_t   evt,
  input logic       sda_oe,
  input logic       wr_valid,
  input logic [7:0] wr_addr,
  input logic [7:0] rd_addr
);
  function automatic logic is_mapped(input logic [7:0] a);
    for (int i = 0; i < NUM_REGS; i++) begin
      if (a == REG_MAP[i*8 +: 8]) return 1'b1;
    end
    return 1'b0;
  endfunction

  // R9: output enable moves only after a falling SCL edge or a bus condition.
  assert_oe_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(evt.fall || evt.start || evt.stop));

  // R10: a START or STOP releases SDA.
  assert_release_on_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.start || evt.stop) |=> !sda_oe);

  // R4: each write beat lasts exactly one cycle.
  assert_single_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R5: no write beat targets an unmapped address.
  assert_mapped_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> is_mapped(wr_addr));

  // R7: the pointer has already stepped past the address being written.
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (rd_addr == wr_addr + 8'd1));
endmodule

bind i2c_reg_target i2c_tgt_checker #(.NUM_REGS(NUM_REGS), .REG_MAP(REG_MAP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt      (evt),
  .sda_oe   (sda_oe),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .rd_addr  (rd_addr)
);

// File: tb/tb_i2c_reg_target.sv
`timescale 1ns/1ps
module tb_i2c_reg_target;
  localparam int Q = 10;  // system clocks per quarter SCL period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_i;
  logic       sda_oe;
  logic       wr_valid;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] hostmem [256];
  logic [7:0] mm [256];
  logic [7:0] mptr = 8'h00;
  logic [7:0] exp_wa [$];
  logic [7:0] exp_wd [$];

  always #4 clk = ~clk;

  assign sda_i   = sda_m & ~sda_oe;
  assign rd_data = hostmem[rd_addr];

  i2c_reg_target #(
    .DEV_ADDR(7'h3A), .NUM_REGS(4),
    .REG_MAP({8'hFF, 8'h10, 8'h01, 8'h00}), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic bit bmapped(input logic [7:0] a);
    return (a == 8'h00) || (a == 8'h01) || (a == 8'h10) || (a == 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Per-clock monitor: write port against the model, SDA timing.
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_valid) begin
        if (exp_wa.size() == 0) begin
          chk(0, "R5 unexpected write beat", int'(wr_addr), 0);
        end else begin
          logic [7:0] ea, ed;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          chk(wr_addr == ea, "R4 write address", int'(wr_addr), int'(ea));
          chk(wr_data == ed, "R4 write data", int'(wr_data), int'(ed));
        end
        hostmem[wr_addr] = wr_data;
      end
      if (sda_oe != prev_oe)
        chk(scl_m == 1'b0, "R9 sda_oe changed while SCL high", int'(scl_m), 0);
      prev_oe = sda_oe;
    end
  end

  task automatic bus_start();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    nack = sda_i;
    wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_i;
      wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = nack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic send_expect(input logic [7:0] b, input bit exp_ack, input string tag);
    logic nk;
    write_byte(b, nk);
    chk(nk == !exp_ack, tag, int'(!nk), int'(exp_ack));
  endtask

  task automatic send_ptr(input logic [7:0] p);
    mptr = p;
    send_expect(p, bmapped(p), bmapped(p) ? "R3 mapped pointer ACK" : "R3 unmapped pointer NACK");
  endtask

  task automatic send_wdata(input logic [7:0] d);
    bit m;
    m = bmapped(mptr);
    if (m) begin
      exp_wa.push_back(mptr);
      exp_wd.push_back(d);
      mm[mptr] = d;
    end
    send_expect(d, m, m ? "R4 mapped write ACK" : "R5 unmapped write NACK");
    mptr = mptr + 8'd1;
  endtask

  task automatic recv(input logic nack);
    logic [7:0] got, exp;
    exp = bmapped(mptr) ? mm[mptr] : 8'h00;
    read_byte(nack, got);
    chk(got == exp, bmapped(mptr) ? "R6 mapped read" : "R6 unmapped read zero", int'(got), int'(exp));
    mptr = mptr + 8'd1;
  endtask

  initial begin
    logic [7:0] junk;
    for (int i = 0; i < 256; i++) begin
      hostmem[i] = 8'(i) ^ 8'h5A;
      mm[i]      = 8'(i) ^ 8'h5A;
    end
    wq(5);
    // R1: reset state
    chk(sda_oe == 1'b0, "R1 sda_oe at reset", int'(sda_oe), 0);
    chk(wr_valid == 1'b0, "R1 wr_valid at reset", int'(wr_valid), 0);
    chk(rd_addr == 8'h00, "R1 rd_addr at reset", int'(rd_addr), 0);
    rst_n = 1'b1;
    wq(5);

    // R2: wrong device address, write direction: whole transfer ignored
    bus_start();
    send_expect({7'h22, 1'b0}, 0, "R2 mismatched address NACK");
    send_expect(8'h10, 0, "R2 ignored pointer byte");
    send_expect(8'h55, 0, "R2 ignored data byte");
    bus_stop();
    chk(rd_addr == 8'h00, "R2 pointer untouched", int'(rd_addr), 0);
    chk(sda_oe == 1'b0, "R10 released after STOP", int'(sda_oe), 0);

    // R2: wrong device address, read direction: bus stays released
    bus_start();
    send_expect({7'h3B, 1'b1}, 0, "R2 mismatched read address NACK");
    read_byte(1'b1, junk);
    chk(junk == 8'hFF, "R2 no data driven", int'(junk), 8'hFF);
    bus_stop();

    // R3/R4/R5: page write across mapped 0x00,0x01 into unmapped 0x02
    bus_start();
    send_expect({7'h3A, 1'b0}, 1, "R2 matched address ACK");
    send_ptr(8'h00);
    send_wdata(8'hA5);
    send_wdata(8'h5C);
    send_wdata(8'h77);
    bus_stop();
    chk(rd_addr == mptr, "R7 pointer after page write", int'(rd_addr), int'(mptr));

    // R3/R5/R7: unmapped pointer still loads, next mapped byte is written
    bus_start();
    send_expect({7'h3A, 1'b0}, 1, "R2 matched address ACK");
    send_ptr(8'h0F);
    send_wdata(8'h11);
    send_wdata(8'h22);
    bus_stop();
    chk(rd_addr == 8'h11, "R7 pointer steps past unmapped", int'(rd_addr), 8'h11);

    // R7: page write across the 0xFF -> 0x00 wrap
    bus_start();
    send_expect({7'h3A, 1'b0}, 1, "R2 matched address ACK");
    send_ptr(8'hFE);
    send_wdata(8'h33);
    send_wdata(8'h44);
    send_wdata(8'h66);
    bus_stop();
    chk(rd_addr == 8'h01, "R7 pointer wrapped", int'(rd_addr), 8'h01);

    // R6/R7/R8: sequential read across the wrap into an unmapped address
    bus_start();
    send_expect({7'h3A, 1'b0}, 1, "R2 matched address ACK");
    send_ptr(8'hFF);
    bus_restart();
    chk(sda_oe == 1'b0, "R10 released after repeated START", int'(sda_oe), 0);
    send_expect({7'h3A, 1'b1}, 1, "R2 matched read address ACK");
    recv(1'b0);
    recv(1'b0);
    recv(1'b0);
    recv(1'b1);
    wq(2*Q);
    chk(sda_oe == 1'b0, "R8 SDA released after controller NACK", int'(sda_oe), 0);
    chk(rd_addr == 8'h03, "R7 pointer after reads", int'(rd_addr), 8'h03);
    bus_stop();

    // R8: repeated START after a NACKed read keeps the pointer
    bus_start();
    send_expect({7'h3A, 1'b0}, 1, "R2 matched address ACK");
    send_ptr(8'h00);
    bus_restart();
    send_expect({7'h3A, 1'b1}, 1, "R2 matched read address ACK");
    recv(1'b1);
    bus_restart();
    send_expect({7'h3A, 1'b1}, 1, "R8 read after repeated START ACK");
    chk(rd_addr == 8'h01, "R8 pointer kept across repeated START", int'(rd_addr), 8'h01);
    recv(1'b1);
    bus_stop();
    chk(sda_oe == 1'b0, "R10 released after final STOP", int'(sda_oe), 0);

    wq(4*Q);
    chk(exp_wa.size() == 0, "R4 all predicted writes seen", exp_wa.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule